// File: doc/BRIEF.md
# Serial Control Register File

This block is the byte-wide control register bank of a memory device. A serial front end, which is not part of the block, hands it one transaction per cycle: a 6-bit device ID, an 8-bit register address, a read/write flag and 8 data bits. The block compares the transaction's device ID with the ID it stores. On a match it performs the access. On a mismatch it drops the transaction without any trace.

The bank holds these registers:

- The device ID. It is loaded from a dedicated initialization port.
- A configuration register with a data-lane width select and a serial write-load enable.
- A power register. Its write-one wake bit puts the device in the active state. A separate powerdown command input returns the device to powerdown.
- A refresh register with the self-refresh bank and the multi-bank refresh count.
- Three bytes of refresh row address.
- Current-strength calibration for the even-numbered and odd-numbered data pins.
- Termination-impedance calibration for the even-numbered and odd-numbered data pins.

Every field is driven continuously to the device core. A read returns its byte on the following cycle, together with a valid strobe. Bits outside the defined fields are never stored and always read as zero.

Top module: `sctl_regfile`

## Requirements
- R1: After reset, every stored field is 0, `pwr_active` is 0 (powerdown) and `rsp_valid` is 0.
- R2: A transaction whose `req_id` differs from the stored device ID causes no register change and no read response.
- R3: The device ID reads at address 0x01 in bits 5:0. It is loaded only by a pulse on `init_id_we`. Serial writes to 0x01 leave it unchanged.
- R4: A matching read raises `rsp_valid` for exactly the next cycle, with the addressed byte on `rsp_rdata`. In every other case `rsp_valid` is 0 on the next cycle.
- R5: Bits outside the defined fields are discarded on write and read as 0. Reads of address 0x00 and of any address from 0x0C up to 0xFF return 0x00.
- R6: The configuration register is at 0x02. Bits 1:0 hold the lane-width select (`cfg_lanes`). Bit 4 holds the serial write-load enable (`cfg_serial_load`).
- R7: The power register is at 0x03. Writing 1 to bit 0 sets `pwr_active`, and writing 0 there has no effect. Bit 0 is write-only and reads 0. Bit 1 is read-only and reads the current `pwr_active`.
- R8: A `pdn_cmd` pulse clears `pwr_active` on the next edge. It takes priority over a wake write in the same cycle.
- R9: The refresh register is at 0x04. Bits 3:0 hold the self-refresh bank (`rf_bank`). Bits 6:4 hold the multi-bank count (`rf_mbr`).
- R10: The refresh row `rf_row` is split across three addresses. Address 0x07 holds bits 7:0. Address 0x06 holds bits 15:8. Address 0x05 holds bits 19:16, in its bits 3:0.
- R11: Calibration is held at four addresses, each in bits 5:0. Address 0x08 holds current for even pins. Address 0x09 holds current for odd pins. Address 0x0A holds impedance for even pins. Address 0x0B holds impedance for odd pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Transaction present this cycle |
| req_id | input | 6 | Device ID carried by the transaction |
| req_addr | input | 8 | Register address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| pdn_cmd | input | 1 | Powerdown command pulse |
| init_id_we | input | 1 | Load the device ID from `init_id` |
| init_id | input | 6 | Device ID value during initialization |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 8 | Read data |
| dev_id | output | 6 | Stored device ID |
| pwr_active | output | 1 | 1 = active, 0 = powerdown |
| cfg_lanes | output | 2 | Lane-width select |
| cfg_serial_load | output | 1 | Serial write-load enable |
| rf_bank | output | 4 | Self-refresh bank |
| rf_mbr | output | 3 | Multi-bank refresh count |
| rf_row | output | 20 | Refresh row address |
| cc_even | output | 6 | Current calibration, even pins |
| cc_odd | output | 6 | Current calibration, odd pins |
| zc_even | output | 6 | Impedance calibration, even pins |
| zc_odd | output | 6 | Impedance calibration, odd pins |

## Verification
The bench builds the block with its default parameters:

- a 6-bit ID,
- a 2-bit lane field,
- a 4-bit bank and a 3-bit count,
- a 20-bit row,
- 6-bit calibration fields.

With these widths, every register except the two full row bytes has reserved bits. Writes of all-ones therefore exercise the masking. The 4-bit upper row byte makes truncation on the high row address visible. Random transactions with half of them carrying the matching ID cover the 256-address read space, including unmapped addresses. The random mix also interleaves powerdown pulses with wake writes.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
   // register slots; slot 0 is unmapped
   localparam int A_ID    = 1;
   localparam int A_CFG   = 2;
   localparam int A_PWR   = 3;
   localparam int A_RBANK = 4;
   localparam int A_ROWH  = 5;
   localparam int A_ROWM  = 6;
   localparam int A_ROWL  = 7;
   localparam int A_CCE   = 8;
   localparam int A_CCO   = 9;
   localparam int A_ZCE   = 10;
   localparam int A_ZCO   = 11;
   localparam int NSLOT   = 12;
   localparam int SEL_W   = $clog2(NSLOT);

   typedef logic [7:0] byte_t;
endpackage

// File: rtl/sctl_match.sv
module sctl_match #(
   parameter int ID_W = 6
) (
   input  logic            valid,
   input  logic [ID_W-1:0] tx_id,
   input  logic [ID_W-1:0] own_id,
   output logic            hit
);
   assign hit = valid && (tx_id == own_id);
endmodule

// File: rtl/sctl_wdec.sv
module sctl_wdec
   import sctl_pkg::*;
(
   input  logic             hit,
   input  logic             wr,
   input  logic [7:0]       addr,
   output logic [NSLOT-1:0] we
);
   for (genvar a = 0; a < NSLOT; a++) begin : g_slot
      assign we[a] = hit && wr && (addr == 8'(a));
   end
endmodule

// File: rtl/sctl_field.sv
module sctl_field #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1 || W > 8) begin : g_bad_w
      $error("sctl_field: W must be 1..8");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end
endmodule

// File: rtl/sctl_rdmux.sv
module sctl_rdmux
   import sctl_pkg::*;
(
   input  byte_t [NSLOT-1:0] img,
   input  logic  [7:0]       addr,
   output byte_t             rd
);
   always_comb begin
      rd = 8'h00;
      if (addr < 8'(NSLOT)) rd = img[addr[SEL_W-1:0]];
   end
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
   import sctl_pkg::*;
#(
   parameter int ID_W   = 6,
   parameter int LANE_W = 2,
   parameter int BANK_W = 4,
   parameter int MBR_W  = 3,
   parameter int ROW_W  = 20,
   parameter int CAL_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ID_W-1:0]   req_id,
   input  logic [7:0]        req_addr,
   input  logic              req_wr,
   input  logic [7:0]        req_wdata,
   input  logic              pdn_cmd,
   input  logic              init_id_we,
   input  logic [ID_W-1:0]   init_id,
   output logic              rsp_valid,
   output logic [7:0]        rsp_rdata,
   output logic [ID_W-1:0]   dev_id,
   output logic              pwr_active,
   output logic [LANE_W-1:0] cfg_lanes,
   output logic              cfg_serial_load,
   output logic [BANK_W-1:0] rf_bank,
   output logic [MBR_W-1:0]  rf_mbr,
   output logic [ROW_W-1:0]  rf_row,
   output logic [CAL_W-1:0]  cc_even,
   output logic [CAL_W-1:0]  cc_odd,
   output logic [CAL_W-1:0]  zc_even,
   output logic [CAL_W-1:0]  zc_odd
);
   localparam int ROWH_W = ROW_W - 16;

   if (ID_W < 1 || ID_W > 8)     begin : g_chk_id   $error("ID_W must be 1..8");   end
   if (LANE_W < 1 || LANE_W > 4) begin : g_chk_lane $error("LANE_W must be 1..4"); end
   if (BANK_W < 1 || BANK_W > 4) begin : g_chk_bank $error("BANK_W must be 1..4"); end
   if (MBR_W < 1 || MBR_W > 3)   begin : g_chk_mbr  $error("MBR_W must be 1..3");  end
   if (ROWH_W < 1 || ROWH_W > 8) begin : g_chk_row  $error("ROW_W must be 17..24"); end
   if (CAL_W < 1 || CAL_W > 8)   begin : g_chk_cal  $error("CAL_W must be 1..8");  end

   logic             hit;
   logic [NSLOT-1:0] we;
   logic [ID_W-1:0]  id_q;
   logic             act_q;
   byte_t            rd_byte;
   byte_t [NSLOT-1:0] img;
   logic [3:0][CAL_W-1:0] cal_q;

   sctl_match #(.ID_W(ID_W)) u_match (
      .valid(req_valid), .tx_id(req_id), .own_id(id_q), .hit(hit)
   );

   sctl_wdec u_wdec (.hit(hit), .wr(req_wr), .addr(req_addr), .we(we));

   // device ID: loaded only from the initialization port
   always_ff @(posedge clk) begin
      if (!rst_n)          id_q <= '0;
      else if (init_id_we) id_q <= init_id;
   end

   // power state: powerdown command beats a wake write
   always_ff @(posedge clk) begin
      if (!rst_n)                       act_q <= 1'b0;
      else if (pdn_cmd)                 act_q <= 1'b0;
      else if (we[A_PWR] && req_wdata[0]) act_q <= 1'b1;
   end

   sctl_field #(.W(LANE_W)) u_lanes (
      .clk(clk), .rst_n(rst_n), .we(we[A_CFG]),
      .d(req_wdata[LANE_W-1:0]), .q(cfg_lanes));
   sctl_field #(.W(1)) u_sload (
      .clk(clk), .rst_n(rst_n), .we(we[A_CFG]),
      .d(req_wdata[4]), .q(cfg_serial_load));
   sctl_field #(.W(BANK_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we[A_RBANK]),
      .d(req_wdata[BANK_W-1:0]), .q(rf_bank));
   sctl_field #(.W(MBR_W)) u_mbr (
      .clk(clk), .rst_n(rst_n), .we(we[A_RBANK]),
      .d(req_wdata[4 +: MBR_W]), .q(rf_mbr));

   // row bytes: k=0 low, k=1 middle, k=2 high (partial)
   for (genvar k = 0; k < 3; k++) begin : g_row
      localparam int W = (k == 2) ? ROWH_W : 8;
      sctl_field #(.W(W)) u_rowb (
         .clk(clk), .rst_n(rst_n), .we(we[A_ROWL-k]),
         .d(req_wdata[W-1:0]), .q(rf_row[8*k +: W]));
   end

   // calibration: current even/odd, impedance even/odd
   for (genvar c = 0; c < 4; c++) begin : g_cal
      sctl_field #(.W(CAL_W)) u_cal (
         .clk(clk), .rst_n(rst_n), .we(we[A_CCE+c]),
         .d(req_wdata[CAL_W-1:0]), .q(cal_q[c]));
   end

   assign cc_even    = cal_q[0];
   assign cc_odd     = cal_q[1];
   assign zc_even    = cal_q[2];
   assign zc_odd     = cal_q[3];
   assign dev_id     = id_q;
   assign pwr_active = act_q;

   always_comb begin
      img          = '0;
      img[A_ID]    = 8'(id_q);
      img[A_CFG]   = 8'(cfg_lanes) | (8'(cfg_serial_load) << 4);
      img[A_PWR]   = {6'b0, act_q, 1'b0};
      img[A_RBANK] = 8'(rf_bank) | (8'(rf_mbr) << 4);
      img[A_ROWH]  = 8'(rf_row[ROW_W-1:16]);
      img[A_ROWM]  = rf_row[15:8];
      img[A_ROWL]  = rf_row[7:0];
      img[A_CCE]   = 8'(cal_q[0]);
      img[A_CCO]   = 8'(cal_q[1]);
      img[A_ZCE]   = 8'(cal_q[2]);
      img[A_ZCO]   = 8'(cal_q[3]);
   end

   sctl_rdmux u_rdmux (.img(img), .addr(req_addr), .rd(rd_byte));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= 8'h00;
      end else begin
         rsp_valid <= hit && !req_wr;
         if (hit && !req_wr) rsp_rdata <= rd_byte;
      end
   end
endmodule

// File: rtl/sctl_regfile_chk.sv
module sctl_regfile_chk #(
   parameter int ID_W   = 6,
   parameter int LANE_W = 2,
   parameter int BANK_W = 4,
   parameter int ROW_W  = 20,
   parameter int CAL_W  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [ID_W-1:0]   req_id,
   input logic [7:0]        req_addr,
   input logic              req_wr,
   input logic [7:0]        req_wdata,
   input logic              pdn_cmd,
   input logic              init_id_we,
   input logic              rsp_valid,
   input logic [7:0]        rsp_rdata,
   input logic [ID_W-1:0]   dev_id,
   input logic              pwr_active,
   input logic [LANE_W-1:0] cfg_lanes,
   input logic [BANK_W-1:0] rf_bank,
   input logic [ROW_W-1:0]  rf_row,
   input logic [CAL_W-1:0]  cc_even
);
   logic mine, rd_mine;
   assign mine    = req_valid && (req_id == dev_id);
   assign rd_mine = mine && !req_wr;

   p_read_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mine |=> rsp_valid);
   p_no_spurious_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_mine |=> !rsp_valid);
   p_foreign_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_id != dev_id && !pdn_cmd && !init_id_we)
      |=> $stable({cfg_lanes, rf_bank, rf_row, cc_even, pwr_active}));
   p_id_only_by_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !init_id_we |=> $stable(dev_id));
   p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_mine && (req_addr == 8'h00 || req_addr >= 8'h0C)) |=> (rsp_rdata == 8'h00));
   p_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mine && req_wr && req_addr == 8'h03 && req_wdata[0] && !pdn_cmd) |=> pwr_active);
   p_pdn_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pdn_cmd |=> !pwr_active);
endmodule

bind sctl_regfile sctl_regfile_chk #(
   .ID_W(ID_W), .LANE_W(LANE_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .CAL_W(CAL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
   .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
   .pdn_cmd(pdn_cmd), .init_id_we(init_id_we), .rsp_valid(rsp_valid),
   .rsp_rdata(rsp_rdata), .dev_id(dev_id), .pwr_active(pwr_active),
   .cfg_lanes(cfg_lanes), .rf_bank(rf_bank), .rf_row(rf_row), .cc_even(cc_even)
);

// File: tb/sctl_regfile_bench.sv
module sctl_regfile_bench;
   localparam int CLK_PERIOD = 10;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_wr = 0, pdn_cmd = 0, init_id_we = 0;
   logic [5:0] req_id = 0, init_id = 0;
   logic [7:0] req_addr = 0, req_wdata = 0;
   logic rsp_valid, pwr_active, cfg_serial_load;
   logic [7:0] rsp_rdata;
   logic [5:0] dev_id, cc_even, cc_odd, zc_even, zc_odd;
   logic [1:0] cfg_lanes;
   logic [3:0] rf_bank;
   logic [2:0] rf_mbr;
   logic [19:0] rf_row;

   int checks = 0, errors = 0;
   bit done = 0;

   logic [7:0] m [0:11];
   logic       m_act;
   logic [5:0] m_id;

   always #(CLK_PERIOD/2) clk = ~clk;

   sctl_regfile u_sctl_regfile (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
      .req_addr(req_addr), .req_wr(req_wr), .req_wdata(req_wdata),
      .pdn_cmd(pdn_cmd), .init_id_we(init_id_we), .init_id(init_id),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dev_id(dev_id),
      .pwr_active(pwr_active), .cfg_lanes(cfg_lanes),
      .cfg_serial_load(cfg_serial_load), .rf_bank(rf_bank), .rf_mbr(rf_mbr),
      .rf_row(rf_row), .cc_even(cc_even), .cc_odd(cc_odd),
      .zc_even(zc_even), .zc_odd(zc_odd)
   );

   // writable bits per address (R5, R6, R9, R10, R11)
   function automatic logic [7:0] wmask(int a);
      case (a)
         2:       return 8'h13;
         4:       return 8'h7F;
         5:       return 8'h0F;
         6, 7:    return 8'hFF;
         8, 9, 10, 11: return 8'h3F;
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] exp_rd(logic [7:0] a);
      if (a == 8'h01) return {2'b00, m_id};
      if (a == 8'h03) return {6'b0, m_act, 1'b0};
      if (a < 8'd12)  return m[a] & wmask(int'(a));
      return 8'h00;
   endfunction

   task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   task automatic check_outs();
      check("R6 cfg outputs", {30'b0, cfg_serial_load, 1'b0} | 32'(cfg_lanes) << 0 | 32'(cfg_serial_load) << 4,
            32'(m[2][1:0]) | (32'(m[2][4]) << 4) | (32'(m[2][4]) << 1));
      check("R7 pwr_active", 32'(pwr_active), 32'(m_act));
      check("R9 bank/mbr", {rf_mbr, rf_bank}, {m[4][6:4], m[4][3:0]});
      check("R10 row", 32'(rf_row), {12'b0, m[5][3:0], m[6], m[7]});
      check("R11 cal", {cc_even, cc_odd, zc_even, zc_odd},
            {m[8][5:0], m[9][5:0], m[10][5:0], m[11][5:0]});
      check("R3 dev_id", 32'(dev_id), 32'(m_id));
   endtask

   task automatic txn(logic [5:0] id, logic [7:0] a, logic wr, logic [7:0] d, logic pdn, string tag);
      logic [7:0] e;
      logic hit;
      @(negedge clk);
      req_valid = 1; req_id = id; req_addr = a; req_wr = wr; req_wdata = d; pdn_cmd = pdn;
      hit = (id == m_id);
      e = exp_rd(a);
      @(negedge clk);
      req_valid = 0; pdn_cmd = 0;
      if (hit && !wr) begin
         check({tag, " R4 rsp_valid"}, 32'(rsp_valid), 32'd1);
         check({tag, " rdata"}, 32'(rsp_rdata), 32'(e));
      end else begin
         check({tag, " R4/R2 no rsp"}, 32'(rsp_valid), 32'd0);
      end
      if (pdn) m_act = 1'b0;
      else if (hit && wr && a == 8'h03 && d[0]) m_act = 1'b1;
      if (hit && wr && a < 8'd12 && wmask(int'(a)) != 0) m[a] = d & wmask(int'(a));
      check_outs();
   endtask

   task automatic load_id(logic [5:0] v);
      @(negedge clk);
      init_id_we = 1; init_id = v;
      @(negedge clk);
      init_id_we = 0;
      m_id = v;
      check("R3 init load", 32'(dev_id), 32'(v));
   endtask

   initial begin
      for (int i = 0; i < 12; i++) m[i] = 8'h00;
      m_act = 0; m_id = 0;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      check("R1 rsp_valid", 32'(rsp_valid), 0);
      check_outs();
      for (int a = 0; a < 12; a++) txn(6'd0, 8'(a), 0, 8'h00, 0, "R1 reset read");

      load_id(6'h2A);
      txn(6'h2A, 8'h01, 0, 0, 0, "R3 id read");
      txn(6'h2A, 8'h01, 1, 8'hFF, 0, "R3 serial write to id");
      txn(6'h2A, 8'h01, 0, 0, 0, "R3 id unchanged");
      txn(6'h00, 8'h02, 1, 8'hFF, 0, "R2 foreign write");
      txn(6'h00, 8'h02, 0, 0, 0, "R2 foreign read");
      txn(6'h2A, 8'h02, 1, 8'hFF, 0, "R6 cfg write");
      txn(6'h2A, 8'h02, 0, 0, 0, "R5 R6 cfg reserved read 0x13");
      txn(6'h2A, 8'h03, 1, 8'h01, 0, "R7 wake");
      txn(6'h2A, 8'h03, 1, 8'h00, 0, "R7 write 0 no effect");
      txn(6'h2A, 8'h03, 0, 0, 0, "R7 pwr read 0x02");
      txn(6'h2A, 8'h03, 1, 8'h01, 1, "R8 pdn beats wake");
      txn(6'h2A, 8'h03, 1, 8'h01, 0, "R7 wake again");
      txn(6'h15, 8'h00, 0, 0, 1, "R8 pdn alone");
      txn(6'h2A, 8'h04, 1, 8'hFF, 0, "R9 bank write");
      txn(6'h2A, 8'h04, 0, 0, 0, "R9 bank read");
      txn(6'h2A, 8'h05, 1, 8'hFF, 0, "R10 row high");
      txn(6'h2A, 8'h06, 1, 8'hA5, 0, "R10 row mid");
      txn(6'h2A, 8'h07, 1, 8'h3C, 0, "R10 row low");
      txn(6'h2A, 8'h05, 0, 0, 0, "R10 row high read");
      for (int c = 8; c < 12; c++) txn(6'h2A, 8'(c), 1, 8'(8'hC0 | c), 0, "R11 cal write");
      for (int c = 8; c < 12; c++) txn(6'h2A, 8'(c), 0, 0, 0, "R11 cal read");
      txn(6'h2A, 8'h00, 0, 0, 0, "R5 unmapped 0x00");
      txn(6'h2A, 8'h0C, 0, 0, 0, "R5 unmapped 0x0C");
      txn(6'h2A, 8'hFF, 0, 0, 0, "R5 unmapped 0xFF");
      txn(6'h2A, 8'h0C, 1, 8'hFF, 0, "R5 unmapped write");

      for (int n = 0; n < 500; n++) begin
         logic [5:0] id;
         logic [7:0] a;
         id = ($urandom() % 2 == 0) ? m_id : 6'($urandom());
         a  = ($urandom() % 4 == 0) ? 8'($urandom()) : 8'($urandom() % 13);
         txn(id, a, 1'($urandom()), 8'($urandom()), ($urandom() % 8 == 0), "random");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule